// File: doc/BRIEF.md
# Parallel Port Mode Handshake Controller

This block runs the host side of the handshake that moves a parallel port from plain compatibility operation into an extended transfer mode, and the handshake that brings it back. Given a start command and an 8-bit request code, it puts the code on the data lines and steps the host control lines through the negotiation events. It watches the peripheral status lines and decides whether the request was accepted, refused, timed out or broke with an I/O error. The return command runs the termination events and always leaves the port in compatibility mode with a forward bus.

All waiting is counted in ticks from an external prescaler enable. Each phase has its own limit: a one-tick setup hold, a six-tick response window, and a seven-tick window for the late acknowledge. The status inputs pass through two-flop synchronisers before the state machine sees them. The block keeps the current mode and the bus direction. A successful nibble request turns the bus to reverse, and any other accepted code keeps it forward.

Top module: `p1284_negotiator`

## Requirements
- R1: After reset nStrobe, nAutoFd and nInit are high, nSelectIn is low, the data lines are 0x00, the controller is idle, the mode is compatibility (code 0) and the direction is forward (dir_rev_o = 0).
- R2: A negotiate command that arrives while nSelectIn is high does not start a handshake. On the next cycle done_o pulses with result I/O error (code 4) and the controller stays idle.
- R3: A negotiate command that arrives while nSelectIn is low loads the request code onto the data lines and holds the control lines unchanged until one tick has passed. It then drives nSelectIn high and nAutoFd low, with nStrobe and nInit high.
- R4: The controller then waits for PError, Select and nFault high with nAck low. If the sixth tick in that wait passes without this, done_o pulses with result timeout (code 3), nSelectIn stays high and nAutoFd stays low.
- R5: Once the response is seen, nStrobe goes low, with nSelectIn high and nAutoFd low, until the next tick. Then nStrobe and nAutoFd both return high.
- R6: After the strobe, nAck must return high within seven ticks. Otherwise done_o pulses with result I/O error (code 4) and the mode stays compatibility.
- R7: When nAck returns high, request code 0x00 is accepted (result code 1) and sets mode nibble (code 1) with the direction reverse. Any other code is accepted only if Select is high at that moment, which sets mode extended (code 2) with the direction forward. Without Select the result is refused (code 2) and the mode stays compatibility.
- R8: A terminate command drives nSelectIn low with nAutoFd, nStrobe and nInit high. It then waits for Busy and nFault high with nAck low. If that is not seen within seven ticks, the result is I/O error (code 4).
- R9: After that acknowledge, nAutoFd goes low and nAck must return high within six ticks. On success nAutoFd returns high and the result is success (code 1). On expiry nAutoFd is also restored high and the result is I/O error (code 4).
- R10: Termination sets the mode to compatibility and the direction to forward, whatever its outcome.
- R11: Commands and changes on the request code are ignored while the controller is busy. The data lines do not change, and a running negotiation completes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable from a prescaler, one cycle per tick |
| cmd_neg | input | 1 | Start negotiation (one-cycle pulse) |
| cmd_term | input | 1 | Start termination (one-cycle pulse) |
| ext_byte | input | 8 | Requested mode code |
| nack_i | input | 1 | Peripheral nAck line |
| busy_i | input | 1 | Peripheral Busy line |
| perror_i | input | 1 | Peripheral PError line |
| select_i | input | 1 | Peripheral Select line |
| nfault_i | input | 1 | Peripheral nFault line |
| pd_o | output | 8 | Host data lines |
| nstrobe_o | output | 1 | Host nStrobe line |
| nautofd_o | output | 1 | Host nAutoFd line |
| nselectin_o | output | 1 | Host nSelectIn line |
| ninit_o | output | 1 | Host nInit line |
| ctrl_busy_o | output | 1 | A handshake is in progress |
| done_o | output | 1 | One-cycle pulse when a command finishes |
| result_o | output | 3 | Last result: 0 none, 1 success, 2 refused, 3 timeout, 4 I/O error |
| mode_o | output | 2 | Current mode: 0 compatibility, 1 nibble, 2 extended |
| dir_rev_o | output | 1 | Bus direction, 1 = reverse |

## Verification
A state machine stuck in the wrong phase shows up on the control lines within one cycle. It would, for example, drop nStrobe while nAutoFd is high, or hold nSelectIn at the wrong level after a failed phase. A wrong phase counter shows up as a done pulse one or more ticks early or late, and the tests measure this by counting ticks between the nSelectIn rise and the done pulse. A wrong accept decision or mode update shows up on mode_o and dir_rev_o in the same cycle as done_o. The tests read the result, mode and direction at that pulse for each kind of request.

// File: rtl/p1284_pkg.sv
package p1284_pkg;

    typedef enum logic [2:0] {
        RES_NONE    = 3'd0,
        RES_OK      = 3'd1,
        RES_REFUSED = 3'd2,
        RES_TIMEOUT = 3'd3,
        RES_IOERR   = 3'd4
    } result_e;

    typedef enum logic [1:0] {
        MODE_COMPAT = 2'd0,
        MODE_NIBBLE = 2'd1,
        MODE_EXT    = 2'd2
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_N_SETUP,
        S_N_RESP,
        S_N_STRB,
        S_N_ACKHI,
        S_T_ACK,
        S_T_ACKHI
    } state_e;

    // Peripheral status as seen after synchronisation
    typedef struct packed {
        logic nack;
        logic busy;
        logic perror;
        logic select;
        logic nfault;
    } status_t;

    // Host-driven control lines
    typedef struct packed {
        logic nstrobe;
        logic nautofd;
        logic nselectin;
        logic ninit;
    } ctl_t;

    localparam ctl_t CTL_COMPAT = '{nstrobe: 1'b1, nautofd: 1'b1, nselectin: 1'b0, ninit: 1'b1};
    localparam ctl_t CTL_REQ    = '{nstrobe: 1'b1, nautofd: 1'b0, nselectin: 1'b1, ninit: 1'b1};
    localparam ctl_t CTL_ACTIVE = '{nstrobe: 1'b1, nautofd: 1'b1, nselectin: 1'b1, ninit: 1'b1};

    localparam logic [7:0] NIBBLE_CODE = 8'h00;

    function automatic logic neg_resp_seen(status_t s);
        return s.perror & s.select & s.nfault & ~s.nack;
    endfunction

    function automatic logic term_ack_seen(status_t s);
        return s.busy & s.nfault & ~s.nack;
    endfunction

endpackage

// File: rtl/p1284_sync.sv
module p1284_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= rst_val;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/p1284_phase_timer.sv
module p1284_phase_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                   cnt_q <= '0;
        else if (tick && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // The limit-th tick seen in the current phase
    assign hit = tick && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/p1284_neg_fsm.sv
module p1284_neg_fsm
    import p1284_pkg::*;
#(
    parameter int T_SETUP = 1,
    parameter int T_RESP  = 6,
    parameter int CW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_neg,
    input  logic          cmd_term,
    input  logic [7:0]    ext_byte,
    input  status_t       st,
    input  logic          hit,
    output logic          tmr_clr,
    output logic [CW-1:0] tmr_limit,
    output ctl_t          ctl,
    output logic [7:0]    pd,
    output logic          busy,
    output logic          done,
    output result_e       result,
    output mode_e         mode,
    output logic          dir_rev
);
    localparam int T_LATE = T_SETUP + T_RESP;
    localparam logic [CW-1:0] LIM_SETUP = CW'(T_SETUP);
    localparam logic [CW-1:0] LIM_RESP  = CW'(T_RESP);
    localparam logic [CW-1:0] LIM_LATE  = CW'(T_LATE);

    state_e     st_q, st_d;
    ctl_t       ctl_q, ctl_d;
    logic [7:0] pd_q, pd_d;
    mode_e      mode_q, mode_d;
    logic       dir_q, dir_d;
    result_e    res_q, res_d;
    logic       done_q, done_d;

    always_comb begin
        st_d      = st_q;
        ctl_d     = ctl_q;
        pd_d      = pd_q;
        mode_d    = mode_q;
        dir_d     = dir_q;
        res_d     = res_q;
        done_d    = 1'b0;
        tmr_limit = LIM_LATE;
        unique case (st_q)
            S_IDLE: begin
                if (cmd_neg) begin
                    if (ctl_q.nselectin) begin
                        done_d = 1'b1;
                        res_d  = RES_IOERR;
                    end else begin
                        pd_d = ext_byte;
                        st_d = S_N_SETUP;
                    end
                end else if (cmd_term) begin
                    ctl_d  = CTL_COMPAT;
                    mode_d = MODE_COMPAT;
                    dir_d  = 1'b0;
                    st_d   = S_T_ACK;
                end
            end
            S_N_SETUP: begin
                tmr_limit = LIM_SETUP;
                if (hit) begin
                    ctl_d = CTL_REQ;
                    st_d  = S_N_RESP;
                end
            end
            S_N_RESP: begin
                tmr_limit = LIM_RESP;
                if (neg_resp_seen(st)) begin
                    ctl_d.nstrobe = 1'b0;
                    st_d          = S_N_STRB;
                end else if (hit) begin
                    done_d = 1'b1;
                    res_d  = RES_TIMEOUT;
                    st_d   = S_IDLE;
                end
            end
            S_N_STRB: begin
                tmr_limit = LIM_SETUP;
                if (hit) begin
                    ctl_d = CTL_ACTIVE;
                    st_d  = S_N_ACKHI;
                end
            end
            S_N_ACKHI: begin
                tmr_limit = LIM_LATE;
                if (st.nack) begin
                    done_d = 1'b1;
                    st_d   = S_IDLE;
                    if (pd_q == NIBBLE_CODE) begin
                        res_d  = RES_OK;
                        mode_d = MODE_NIBBLE;
                        dir_d  = 1'b1;
                    end else if (st.select) begin
                        res_d  = RES_OK;
                        mode_d = MODE_EXT;
                        dir_d  = 1'b0;
                    end else begin
                        res_d  = RES_REFUSED;
                    end
                end else if (hit) begin
                    done_d = 1'b1;
                    res_d  = RES_IOERR;
                    st_d   = S_IDLE;
                end
            end
            S_T_ACK: begin
                tmr_limit = LIM_LATE;
                if (term_ack_seen(st)) begin
                    ctl_d.nautofd = 1'b0;
                    st_d          = S_T_ACKHI;
                end else if (hit) begin
                    done_d = 1'b1;
                    res_d  = RES_IOERR;
                    st_d   = S_IDLE;
                end
            end
            S_T_ACKHI: begin
                tmr_limit = LIM_RESP;
                if (st.nack) begin
                    ctl_d.nautofd = 1'b1;
                    done_d        = 1'b1;
                    res_d         = RES_OK;
                    st_d          = S_IDLE;
                end else if (hit) begin
                    ctl_d.nautofd = 1'b1;
                    done_d        = 1'b1;
                    res_d         = RES_IOERR;
                    st_d          = S_IDLE;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    assign tmr_clr = (st_d != st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            ctl_q  <= CTL_COMPAT;
            pd_q   <= '0;
            mode_q <= MODE_COMPAT;
            dir_q  <= 1'b0;
            res_q  <= RES_NONE;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            pd_q   <= pd_d;
            mode_q <= mode_d;
            dir_q  <= dir_d;
            res_q  <= res_d;
            done_q <= done_d;
        end
    end

    assign ctl     = ctl_q;
    assign pd      = pd_q;
    assign busy    = (st_q != S_IDLE);
    assign done    = done_q;
    assign result  = res_q;
    assign mode    = mode_q;
    assign dir_rev = dir_q;
endmodule

// File: rtl/p1284_negotiator.sv
module p1284_negotiator
    import p1284_pkg::*;
#(
    parameter int T_SETUP     = 1,
    parameter int T_RESP      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cmd_neg,
    input  logic       cmd_term,
    input  logic [7:0] ext_byte,
    input  logic       nack_i,
    input  logic       busy_i,
    input  logic       perror_i,
    input  logic       select_i,
    input  logic       nfault_i,
    output logic [7:0] pd_o,
    output logic       nstrobe_o,
    output logic       nautofd_o,
    output logic       nselectin_o,
    output logic       ninit_o,
    output logic       ctrl_busy_o,
    output logic       done_o,
    output logic [2:0] result_o,
    output logic [1:0] mode_o,
    output logic       dir_rev_o
);
    localparam int T_LATE = T_SETUP + T_RESP;
    localparam int CW     = $clog2(T_LATE + 1);
    localparam int SW     = $bits(status_t);
    localparam status_t ST_RST = '{nack: 1'b1, busy: 1'b0, perror: 1'b0, select: 1'b0, nfault: 1'b1};

    status_t       st_raw, st_sync;
    logic          hit, tmr_clr;
    logic [CW-1:0] tmr_limit;
    ctl_t          ctl;
    result_e       result;
    mode_e         mode;

    assign st_raw = '{nack: nack_i, busy: busy_i, perror: perror_i,
                      select: select_i, nfault: nfault_i};

    p1284_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       (st_raw),
        .rst_val (ST_RST),
        .q       (st_sync)
    );

    p1284_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .tick  (tick),
        .limit (tmr_limit),
        .hit   (hit)
    );

    p1284_neg_fsm #(.T_SETUP(T_SETUP), .T_RESP(T_RESP), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_neg   (cmd_neg),
        .cmd_term  (cmd_term),
        .ext_byte  (ext_byte),
        .st        (st_sync),
        .hit       (hit),
        .tmr_clr   (tmr_clr),
        .tmr_limit (tmr_limit),
        .ctl       (ctl),
        .pd        (pd_o),
        .busy      (ctrl_busy_o),
        .done      (done_o),
        .result    (result),
        .mode      (mode),
        .dir_rev   (dir_rev_o)
    );

    assign nstrobe_o   = ctl.nstrobe;
    assign nautofd_o   = ctl.nautofd;
    assign nselectin_o = ctl.nselectin;
    assign ninit_o     = ctl.ninit;
    assign result_o    = result;
    assign mode_o      = mode;
endmodule

// File: rtl/p1284_negotiator_chk.sv
module p1284_negotiator_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       cmd_neg,
    input logic       cmd_term,
    input logic [7:0] ext_byte,
    input logic       nack_i,
    input logic       busy_i,
    input logic       perror_i,
    input logic       select_i,
    input logic       nfault_i,
    input logic [7:0] pd_o,
    input logic       nstrobe_o,
    input logic       nautofd_o,
    input logic       nselectin_o,
    input logic       ninit_o,
    input logic       ctrl_busy_o,
    input logic       done_o,
    input logic [2:0] result_o,
    input logic [1:0] mode_o,
    input logic       dir_rev_o
);
    // R2: a start with nSelectIn high is refused on the next cycle
    a_r2_blocked_start: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_busy_o && cmd_neg && nselectin_o) |=> (!ctrl_busy_o && done_o && result_o == 3'd4));

    // R5: strobe is only pulsed inside the negotiation request phase
    a_r5_strobe_in_request: assert property (@(posedge clk) disable iff (rst)
        !nstrobe_o |-> (nselectin_o && !nautofd_o && ctrl_busy_o));

    // R7: a mode other than compatibility only appears with a successful completion
    a_r7_mode_on_accept: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd0 && mode_o != $past(mode_o)) |-> (done_o && result_o == 3'd1));

    // R10: compatibility mode always has a forward bus
    a_r10_compat_forward: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0) |-> !dir_rev_o);

    // R11: data lines are frozen while a handshake runs
    a_r11_data_frozen: assert property (@(posedge clk) disable iff (rst)
        ctrl_busy_o |=> $stable(pd_o));

    // R1: every completion carries a real result
    a_r1_done_has_result: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o != 3'd0));

    // R8: nInit stays high in every phase
    a_r8_init_high: assert property (@(posedge clk) disable iff (rst)
        ninit_o);
endmodule

bind p1284_negotiator p1284_negotiator_chk i_chk (.*);

// File: tb/test_p1284_negotiator.sv
module test_p1284_negotiator;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick;
    logic       cmd_neg = 1'b0, cmd_term = 1'b0;
    logic [7:0] ext_byte = 8'h00;
    logic       nack_i = 1'b1, busy_i = 1'b0, perror_i = 1'b0, select_i = 1'b1, nfault_i = 1'b1;
    logic [7:0] pd_o;
    logic       nstrobe_o, nautofd_o, nselectin_o, ninit_o;
    logic       ctrl_busy_o, done_o, dir_rev_o;
    logic [2:0] result_o;
    logic [1:0] mode_o;
    logic [1:0] div;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Prescaler model: one tick every four cycles
    always @(posedge clk) begin
        if (rst) begin
            div  <= '0;
            tick <= 1'b0;
        end else begin
            div  <= div + 2'd1;
            tick <= (div == 2'd3);
        end
    end

    p1284_negotiator i_p1284_negotiator (
        .clk(clk), .rst(rst), .tick(tick), .cmd_neg(cmd_neg), .cmd_term(cmd_term),
        .ext_byte(ext_byte), .nack_i(nack_i), .busy_i(busy_i), .perror_i(perror_i),
        .select_i(select_i), .nfault_i(nfault_i), .pd_o(pd_o), .nstrobe_o(nstrobe_o),
        .nautofd_o(nautofd_o), .nselectin_o(nselectin_o), .ninit_o(ninit_o),
        .ctrl_busy_o(ctrl_busy_o), .done_o(done_o), .result_o(result_o),
        .mode_o(mode_o), .dir_rev_o(dir_rev_o)
    );

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_status();
        nack_i = 1'b1; busy_i = 1'b0; perror_i = 1'b0; select_i = 1'b1; nfault_i = 1'b1;
    endtask

    task automatic wait_done(output int res);
        for (int g = 0; g < 400 && !done_o; g++) @(negedge clk);
        res = done_o ? int'(result_o) : -1;
    endtask

    task automatic pulse_neg(input logic [7:0] b);
        @(negedge clk);
        cmd_neg = 1'b1; ext_byte = b;
        @(negedge clk);
        cmd_neg = 1'b0;
    endtask

    task automatic pulse_term();
        @(negedge clk);
        cmd_term = 1'b1;
        @(negedge clk);
        cmd_term = 1'b0;
    endtask

    // Full negotiation with a cooperative peripheral
    task automatic t_negotiate(input logic [7:0] b, input logic sel_at_ack, input bit poke,
                               input int exp_res, input int exp_mode, input int exp_dir);
        int res;
        pulse_neg(b);
        chk("R3 data lines hold code", pd_o, b);
        if (poke) begin
            cmd_term = 1'b1; ext_byte = 8'hFF;
            @(negedge clk);
            cmd_term = 1'b0;
            chk("R11 data unchanged while busy", pd_o, b);
            chk("R11 still busy", ctrl_busy_o, 1);
            chk("R11 mode untouched", mode_o, 0);
        end
        for (int g = 0; g < 100 && !nselectin_o; g++) @(negedge clk);
        chk("R3 nAutoFd low in request", nautofd_o, 0);
        chk("R3 nStrobe high in request", nstrobe_o, 1);
        perror_i = 1'b1; select_i = 1'b1; nfault_i = 1'b1; nack_i = 1'b0;
        for (int g = 0; g < 100 && nstrobe_o; g++) @(negedge clk);
        chk("R5 strobe low", nstrobe_o, 0);
        chk("R5 nAutoFd low with strobe", nautofd_o, 0);
        for (int g = 0; g < 100 && !nstrobe_o; g++) @(negedge clk);
        chk("R5 nAutoFd high after strobe", nautofd_o, 1);
        select_i = sel_at_ack; nack_i = 1'b1;
        wait_done(res);
        chk("R7 result", res, exp_res);
        chk("R7 mode", mode_o, exp_mode);
        chk("R7 direction", dir_rev_o, exp_dir);
        idle_status();
    endtask

    task automatic t_terminate_ok();
        int res;
        pulse_term();
        chk("R8 nSelectIn low", nselectin_o, 0);
        chk("R8 nAutoFd high", nautofd_o, 1);
        chk("R10 mode compat at once", mode_o, 0);
        busy_i = 1'b1; nfault_i = 1'b1; nack_i = 1'b0;
        for (int g = 0; g < 100 && nautofd_o; g++) @(negedge clk);
        chk("R9 nAutoFd low after ack", nautofd_o, 0);
        nack_i = 1'b1;
        wait_done(res);
        chk("R9 termination result", res, 1);
        chk("R9 nAutoFd restored", nautofd_o, 1);
        chk("R10 mode compat", mode_o, 0);
        chk("R10 direction forward", dir_rev_o, 0);
        idle_status();
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 nStrobe", nstrobe_o, 1);
        chk("R1 nAutoFd", nautofd_o, 1);
        chk("R1 nSelectIn", nselectin_o, 0);
        chk("R1 nInit", ninit_o, 1);
        chk("R1 data", pd_o, 0);
        chk("R1 idle", ctrl_busy_o, 0);
        chk("R1 mode", mode_o, 0);
        chk("R1 direction", dir_rev_o, 0);
    endtask

    task automatic t_blocked_start();
        pulse_neg(8'h30);
        chk("R2 done at once", done_o, 1);
        chk("R2 io error", result_o, 4);
        chk("R2 no handshake", ctrl_busy_o, 0);
        chk("R2 data unchanged", pd_o, 0);
    endtask

    task automatic t_timeout();
        int n;
        pulse_neg(8'h30);
        for (int g = 0; g < 100 && !nselectin_o; g++) @(negedge clk);
        n = 0;
        for (int g = 0; g < 400 && !done_o; g++) begin
            if (tick) n++;
            @(negedge clk);
        end
        chk("R4 ticks before timeout", n, 6);
        chk("R4 timeout result", result_o, 3);
        chk("R4 nSelectIn stays high", nselectin_o, 1);
        chk("R4 nAutoFd stays low", nautofd_o, 0);
        chk("R4 mode compat", mode_o, 0);
    endtask

    task automatic t_term_noresp();
        int res;
        pulse_term();
        wait_done(res);
        chk("R8 no ack gives io error", res, 4);
        chk("R8 nSelectIn low", nselectin_o, 0);
        chk("R10 mode compat after failure", mode_o, 0);
    endtask

    task automatic t_term_phase2_fail();
        int res;
        pulse_term();
        busy_i = 1'b1; nack_i = 1'b0;
        for (int g = 0; g < 100 && nautofd_o; g++) @(negedge clk);
        chk("R9 nAutoFd low", nautofd_o, 0);
        wait_done(res);
        chk("R9 late nAck gives io error", res, 4);
        chk("R9 nAutoFd restored on failure", nautofd_o, 1);
        chk("R10 direction forward after failure", dir_rev_o, 0);
        idle_status();
        @(negedge clk);
    endtask

    task automatic t_neg_ackhi_fail();
        int res;
        pulse_neg(8'h30);
        for (int g = 0; g < 100 && !nselectin_o; g++) @(negedge clk);
        perror_i = 1'b1; select_i = 1'b1; nfault_i = 1'b1; nack_i = 1'b0;
        wait_done(res);
        chk("R6 nAck never high gives io error", res, 4);
        chk("R6 mode compat", mode_o, 0);
        idle_status();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        idle_status();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_negotiate(8'h00, 1'b0, 1'b0, 1, 1, 1);   // R7 nibble accepted without Select
        t_blocked_start();                          // R2 nSelectIn high now
        t_terminate_ok();
        t_negotiate(8'h30, 1'b1, 1'b0, 1, 2, 0);   // R7 extended accepted
        t_terminate_ok();
        t_negotiate(8'h30, 1'b0, 1'b0, 2, 0, 0);   // R7 refused
        t_terminate_ok();
        t_timeout();
        t_term_noresp();
        t_term_phase2_fail();
        t_neg_ackhi_fail();
        t_terminate_ok();
        t_negotiate(8'h00, 1'b0, 1'b1, 1, 1, 1);   // R11 commands ignored while busy
        t_terminate_ok();
        report();
        $finish;
    end
endmodule